// File: doc/BRIEF.md
# Debug Memory Access Port Bus Master

This block sits behind a debug port and turns its access-port register requests into single transfers on a simple memory bus. A request carries a read-not-write flag, a four-bit bank number (the bank the debug port has selected) and a two-bit word offset within that bank, plus write data. The bank and offset together pick one register. Control, address and identification registers are handled locally. The data window and the four banked data windows become bus reads or writes at the held transfer address.

Each accepted request ends with a one-cycle done pulse that carries the read data and an error flag. The debug port uses the error flag to raise its sticky error. Only one request is in flight at a time. A request that arrives while a previous one is still running is dropped. The sequencer has four states. IDLE goes to REG_ACK when it accepts a register access, and to BUS_WAIT when it accepts a data access. BUS_WAIT stays put until the bus signals ready, then goes to BUS_ACK. REG_ACK and BUS_ACK both return to IDLE after one cycle.

Top module: `memap_bus_master`

## Requirements
- R1: After reset the control word reads 0x00000002 (32-bit size, increment off), the transfer address reads 0, and neither `bus_req` nor `resp_done` is high.
- R2: The bank and offset decode as follows: bank 0 offset 0 is the control word, bank 0 offset 1 is the transfer address, bank 0 offset 3 is the data window, bank 1 offsets 0 to 3 are banked windows 0 to 3, and bank 15 offsets 1, 2 and 3 are configuration, base pointer and identification. Every other combination reads as zero, ignores writes and starts no bus transfer.
- R3: A write to the control word keeps bits [2:0] as the size code and bits [5:4] as the increment mode. Every other bit of the control word reads as zero.
- R4: An access to the data window makes exactly one bus transfer at the transfer address, with `bus_we` equal to not read-not-write and the write data passed unchanged. `bus_size` is 0 for size code 000 (8-bit), 1 for 001 (16-bit) and 2 for 010 or any reserved code (32-bit).
- R5: Bus read data is zero-extended to the transfer size: only bits [7:0] are kept for 8-bit and only [15:0] for 16-bit. A write returns zero data.
- R6: With increment mode 01, a data-window transfer that succeeds adds 1, 2 or 4 to the transfer address according to its size. Modes 00, 10 and 11 leave the address unchanged.
- R7: Banked window n makes a 32-bit transfer at the transfer address plus 4n and never changes the transfer address.
- R8: A transfer that ends with `bus_err` high returns `resp_err` high with zero read data and does not increment the transfer address. Register accesses never report an error.
- R9: Configuration bit 0 reports the big-endian parameter. The base pointer and identification registers return their parameter values. Writes to all three are ignored.
- R10: `resp_done` is a one-cycle pulse, given once for each accepted request. For a register access it comes in the second cycle after acceptance, with no bus transfer. Requests that arrive while a previous one is in progress are ignored.
- R11: `bus_req` stays high, with address, size, direction and write data stable, until the cycle in which `bus_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe from the debug port |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_bank | input | 4 | Selected register bank |
| req_off | input | 2 | Word offset inside the bank |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | Request completed (one-cycle pulse) |
| resp_rdata | output | 32 | Read data, valid with resp_done |
| resp_err | output | 1 | Transfer error, valid with resp_done |
| bus_req | output | 1 | Bus transfer request |
| bus_addr | output | 32 | Byte address of the transfer |
| bus_size | output | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| bus_we | output | 1 | 1 = write transfer |
| bus_wdata | output | 32 | Right-aligned write data |
| bus_ready | input | 1 | Bus transfer completes this cycle |
| bus_rdata | input | 32 | Bus read data, valid with bus_ready |
| bus_err | input | 1 | Bus transfer failed, valid with bus_ready |

## Verification
The case that is hardest to reach from the ports is a second request arriving while a bus transfer is stalled. The debug port would normally wait for the done pulse, so this never happens in ordinary use. The bench forces a long bus stall, pulses a write to the transfer address in the middle of it, and then reads the address back to show that the write was dropped, counting done pulses along the way. Error and increment interplay is reached by steering the transfer address into a bench region whose transfers always fail, while the random stimulus varies the size code and increment mode.

// File: rtl/memap_pkg.sv
package memap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REG_ACK,
        ST_BUS_WAIT,
        ST_BUS_ACK
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_CSW,
        K_TAR,
        K_DRW,
        K_BD,
        K_CFG,
        K_BASE,
        K_IDR
    } reg_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // Control-word size code to bus size; reserved codes run as words.
    function automatic logic [1:0] code_to_size(input logic [2:0] code);
        case (code)
            3'b000:  return SZ_BYTE;
            3'b001:  return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/memap_decode.sv
module memap_decode #(
    parameter int BANK_W = 4
) (
    input  logic [BANK_W-1:0]      bank,
    input  logic [1:0]             off,
    output memap_pkg::reg_kind_e   kind
);
    import memap_pkg::*;

    localparam logic [BANK_W-1:0] BANK_MAIN = BANK_W'(0);
    localparam logic [BANK_W-1:0] BANK_WIN  = BANK_W'(1);
    localparam logic [BANK_W-1:0] BANK_INFO = {BANK_W{1'b1}};

    always_comb begin
        kind = K_NONE;
        if (bank == BANK_MAIN) begin
            unique case (off)
                2'd0: kind = K_CSW;
                2'd1: kind = K_TAR;
                2'd3: kind = K_DRW;
                default: kind = K_NONE;
            endcase
        end else if (bank == BANK_WIN) begin
            kind = K_BD;
        end else if (bank == BANK_INFO) begin
            unique case (off)
                2'd1: kind = K_CFG;
                2'd2: kind = K_BASE;
                2'd3: kind = K_IDR;
                default: kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/memap_regs.sv
module memap_regs #(
    parameter int          AW       = 32,
    parameter logic [31:0] BASE_VAL = 32'h0000_0003,
    parameter logic [31:0] IDR_VAL  = 32'h0477_0001,
    parameter logic        BIG_END  = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  memap_pkg::reg_kind_e  wr_kind,
    input  logic [31:0]           wr_data,
    input  memap_pkg::reg_kind_e  rd_kind,
    input  logic                  tar_bump,
    output logic [31:0]           rd_data,
    output logic [AW-1:0]         tar,
    output logic [2:0]            size_code,
    output logic [1:0]            inc_mode
);
    import memap_pkg::*;

    localparam logic [1:0] INC_SINGLE = 2'b01;

    logic [AW-1:0] step;

    always_comb begin
        step = AW'(1) << code_to_size(size_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_code <= 3'b010;
            inc_mode  <= 2'b00;
            tar       <= '0;
        end else if (wr_en) begin
            if (wr_kind == K_CSW) begin
                size_code <= wr_data[2:0];
                inc_mode  <= wr_data[5:4];
            end else if (wr_kind == K_TAR) begin
                tar <= wr_data[AW-1:0];
            end
        end else if (tar_bump && inc_mode == INC_SINGLE) begin
            tar <= tar + step;
        end
    end

    always_comb begin
        unique case (rd_kind)
            K_CSW:   rd_data = {26'd0, inc_mode, 1'b0, size_code};
            K_TAR:   rd_data = 32'(tar);
            K_CFG:   rd_data = {31'd0, BIG_END};
            K_BASE:  rd_data = BASE_VAL;
            K_IDR:   rd_data = IDR_VAL;
            default: rd_data = 32'd0;
        endcase
    end

    // R6: increment modes other than 01 never move the address
    assert_no_bump_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tar_bump && inc_mode != INC_SINGLE && !wr_en) |=> $stable(tar));

    // R9: writes to read-only or unmapped registers leave all state alone
    assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind != K_CSW && wr_kind != K_TAR && !tar_bump)
        |=> ($stable(tar) && $stable(size_code) && $stable(inc_mode)));

endmodule

// File: rtl/memap_seq.sv
module memap_seq #(
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_rnw,
    input  memap_pkg::reg_kind_e  req_kind,
    input  logic [1:0]            req_off,
    input  logic [31:0]           req_wdata,
    input  logic [31:0]           reg_rdata,
    input  logic [AW-1:0]         tar,
    input  logic [2:0]            size_code,
    output logic                  reg_wr_en,
    output logic                  tar_bump,
    output logic                  bus_req,
    output logic [AW-1:0]         bus_addr,
    output logic [1:0]            bus_size,
    output logic                  bus_we,
    output logic [31:0]           bus_wdata,
    input  logic                  bus_ready,
    input  logic [31:0]           bus_rdata,
    input  logic                  bus_err,
    output logic                  resp_done,
    output logic [31:0]           resp_rdata,
    output logic                  resp_err
);
    import memap_pkg::*;

    seq_state_e state, state_nx;
    reg_kind_e  kind_q;
    logic       we_q, err_q;
    logic [1:0] sz_q;
    logic [AW-1:0] addr_q;
    logic [31:0] wdata_q, rbuf_q;
    logic       accept, is_data;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign is_data = (req_kind == K_DRW) || (req_kind == K_BD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = is_data ? ST_BUS_WAIT : ST_REG_ACK;
            ST_REG_ACK:  state_nx = ST_IDLE;
            ST_BUS_WAIT: if (bus_ready) state_nx = ST_BUS_ACK;
            ST_BUS_ACK:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_NONE;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            sz_q    <= SZ_WORD;
            addr_q  <= '0;
            wdata_q <= '0;
            rbuf_q  <= '0;
        end else if (accept) begin
            kind_q  <= req_kind;
            we_q    <= !req_rnw;
            err_q   <= 1'b0;
            wdata_q <= req_wdata;
            addr_q  <= (req_kind == K_BD) ? tar + AW'({req_off, 2'b00}) : tar;
            sz_q    <= (req_kind == K_BD) ? SZ_WORD : code_to_size(size_code);
            rbuf_q  <= (req_rnw && !is_data) ? reg_rdata : 32'd0;
        end else if (state == ST_BUS_WAIT && bus_ready) begin
            err_q  <= bus_err;
            rbuf_q <= (!we_q && !bus_err) ? (bus_rdata & size_mask(sz_q)) : 32'd0;
        end
    end

    always_comb begin
        reg_wr_en  = accept && !req_rnw && !is_data;
        bus_req    = (state == ST_BUS_WAIT);
        bus_addr   = addr_q;
        bus_size   = sz_q;
        bus_we     = we_q;
        bus_wdata  = wdata_q;
        tar_bump   = (state == ST_BUS_WAIT) && bus_ready && !bus_err && (kind_q == K_DRW);
        resp_done  = (state == ST_REG_ACK) || (state == ST_BUS_ACK);
        resp_err   = (state == ST_BUS_ACK) && err_q;
        resp_rdata = rbuf_q;
    end

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    // R11: a stalled request holds steady
    assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                      && $stable(bus_wdata) && $stable(bus_size)));

    // R8: an error is only reported together with completion
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_done);

    // R4: only the three legal bus sizes appear
    assert_bus_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_size != 2'd3));

    // R7: a banked-window transfer finishing does not move the address
    assert_bd_keeps_tar_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS_WAIT && bus_ready && kind_q == K_BD) |=> $stable(tar));

endmodule

// File: rtl/memap_bus_master.sv
module memap_bus_master #(
    parameter int          AW       = 32,
    parameter int          BANK_W   = 4,
    parameter logic [31:0] BASE_VAL = 32'h0000_0003,
    parameter logic [31:0] IDR_VAL  = 32'h0477_0001,
    parameter logic        BIG_END  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rnw,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [1:0]        req_off,
    input  logic [31:0]       req_wdata,
    output logic              resp_done,
    output logic [31:0]       resp_rdata,
    output logic              resp_err,
    output logic              bus_req,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_we,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_err
);
    import memap_pkg::*;

    reg_kind_e     kind;
    logic [31:0]   reg_rdata;
    logic [AW-1:0] tar;
    logic [2:0]    size_code;
    logic [1:0]    inc_mode;
    logic          reg_wr_en, tar_bump;

    memap_decode #(.BANK_W(BANK_W)) decode_i (
        .bank (req_bank),
        .off  (req_off),
        .kind (kind)
    );

    memap_regs #(
        .AW(AW), .BASE_VAL(BASE_VAL), .IDR_VAL(IDR_VAL), .BIG_END(BIG_END)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_kind   (kind),
        .wr_data   (req_wdata),
        .rd_kind   (kind),
        .tar_bump  (tar_bump),
        .rd_data   (reg_rdata),
        .tar       (tar),
        .size_code (size_code),
        .inc_mode  (inc_mode)
    );

    memap_seq #(.AW(AW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_rnw    (req_rnw),
        .req_kind   (kind),
        .req_off    (req_off),
        .req_wdata  (req_wdata),
        .reg_rdata  (reg_rdata),
        .tar        (tar),
        .size_code  (size_code),
        .reg_wr_en  (reg_wr_en),
        .tar_bump   (tar_bump),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata),
        .resp_err   (resp_err)
    );

endmodule

// File: tb/memap_bus_master_tb_top.sv
module memap_bus_master_tb_top;

    localparam logic [31:0] T_BASE = 32'hE00F_F003;
    localparam logic [31:0] T_IDR  = 32'h2477_0011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_rnw = 1'b0;
    logic [3:0]  req_bank = '0;
    logic [1:0]  req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_done, resp_err;
    logic [31:0] resp_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_ready = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int nchk = 0, nfail = 0;
    int wcnt = 0, xfers = 0;
    logic [31:0] last_addr = '0, last_wdata = '0;
    logic [1:0]  last_size = '0;
    logic        last_we = 1'b0;
    logic [31:0] slv_mem [64];
    logic [31:0] mdl_mem [64];
    logic [2:0]  m_size;
    logic [1:0]  m_inc;
    logic [31:0] m_tar;

    always #5 clk = ~clk;

    memap_bus_master #(.BASE_VAL(T_BASE), .IDR_VAL(T_IDR), .BIG_END(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_rnw(req_rnw), .req_bank(req_bank),
        .req_off(req_off), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [1:0] bsz(input logic [2:0] c);
        return (c == 3'b000) ? 2'd0 : (c == 3'b001) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [31:0] msk(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // Bus slave: addresses with top byte 0xEE always fail.
    always @(negedge clk) begin
        bus_ready = 1'b0;
        bus_err   = 1'b0;
        if (bus_req) begin
            if (wcnt == 0) begin
                bus_ready  = 1'b1;
                xfers++;
                last_addr  = bus_addr;
                last_size  = bus_size;
                last_we    = bus_we;
                last_wdata = bus_wdata;
                if (bus_addr[31:24] == 8'hEE) begin
                    bus_err   = 1'b1;
                    bus_rdata = $urandom;
                end else if (bus_we) begin
                    slv_mem[bus_addr[7:2]] = bus_wdata;
                end else begin
                    bus_rdata = slv_mem[bus_addr[7:2]];
                end
                wcnt = $urandom % 4;
            end else begin
                wcnt--;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic rnw, input logic [3:0] bank, input logic [1:0] off,
                         input logic [31:0] wd, output logic [31:0] rd, output logic er);
        int t = 0;
        req_valid = 1'b1; req_rnw = rnw; req_bank = bank; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_done && t < 100) begin
            @(negedge clk);
            t++;
        end
        if (!resp_done) begin
            nfail++;
            $display("FAIL R10 watchdog: no completion actual=0 expected=1");
        end
        rd = resp_rdata;
        er = resp_err;
        @(negedge clk);
    endtask

    task automatic reg_rd(input string tag, input logic [3:0] bank, input logic [1:0] off,
                          input logic [31:0] exp);
        logic [31:0] rd; logic er; int x0 = xfers;
        do_op(1'b1, bank, off, 32'd0, rd, er);
        chk(tag, rd, exp);
        chk({tag, " no error/no transfer"}, {31'd0, er} | ((xfers != x0) ? 32'h2 : 32'h0), 32'd0);
    endtask

    task automatic reg_wr(input logic [3:0] bank, input logic [1:0] off, input logic [31:0] wd);
        logic [31:0] rd; logic er;
        do_op(1'b0, bank, off, wd, rd, er);
        if (bank == 4'h0 && off == 2'd0) begin m_size = wd[2:0]; m_inc = wd[5:4]; end
        if (bank == 4'h0 && off == 2'd1) m_tar = wd;
    endtask

    task automatic data_op(input logic rnw, input logic bd, input logic [1:0] n,
                           input logic [31:0] wd);
        logic [31:0] ea, rd, ed; logic [1:0] es; logic ee, er; int x0 = xfers;
        ea = bd ? m_tar + {28'd0, n, 2'b00} : m_tar;
        es = bd ? 2'd2 : bsz(m_size);
        ee = (ea[31:24] == 8'hEE);
        do_op(rnw, bd ? 4'h1 : 4'h0, bd ? n : 2'd3, wd, rd, er);
        chk(bd ? "R7 address" : "R4 address", last_addr, ea);
        chk("R4 size", {30'd0, last_size}, {30'd0, es});
        chk("R4 direction", {31'd0, last_we}, {31'd0, !rnw});
        chk("R10 one transfer", xfers - x0, 1);
        if (!rnw) chk("R4 write data", last_wdata, wd);
        ed = (rnw && !ee) ? (mdl_mem[ea[7:2]] & msk(es)) : 32'd0;
        chk("R5 read data", rd, ed);
        chk("R8 error flag", {31'd0, er}, {31'd0, ee});
        if (!rnw && !ee) mdl_mem[ea[7:2]] = wd;
        if (!bd && !ee && m_inc == 2'b01) m_tar = m_tar + (32'd1 << es);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nfail++;
                $display("FAIL R10 global watchdog actual=%0d expected<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd; logic er;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            slv_mem[i] = $urandom;
            mdl_mem[i] = slv_mem[i];
        end
        m_size = 3'b010; m_inc = 2'b00; m_tar = 32'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done low", {31'd0, resp_done}, 32'd0);
        chk("R1 bus idle", {31'd0, bus_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_rd("R1 control word", 4'h0, 2'd0, 32'h0000_0002);
        reg_rd("R1 transfer address", 4'h0, 2'd1, 32'd0);

        // R3: control word fields
        reg_wr(4'h0, 2'd0, 32'hFFFF_FFF9);
        reg_rd("R3 control word readback", 4'h0, 2'd0, 32'h0000_0031);

        // R9: identification registers and ignored writes
        reg_rd("R9 config", 4'hF, 2'd1, 32'd1);
        reg_rd("R9 base", 4'hF, 2'd2, T_BASE);
        reg_rd("R9 ident", 4'hF, 2'd3, T_IDR);
        do_op(1'b0, 4'hF, 2'd3, 32'h0, rd, er);
        do_op(1'b0, 4'hF, 2'd1, 32'h0, rd, er);
        reg_rd("R9 ident after write", 4'hF, 2'd3, T_IDR);
        reg_rd("R9 config after write", 4'hF, 2'd1, 32'd1);

        // R2: unmapped locations
        reg_wr(4'h0, 2'd1, 32'h2000_0040);
        do_op(1'b0, 4'h0, 2'd2, 32'hDEAD_BEEF, rd, er);
        do_op(1'b0, 4'h7, 2'd1, 32'hDEAD_BEEF, rd, er);
        reg_rd("R2 unmapped bank0", 4'h0, 2'd2, 32'd0);
        reg_rd("R2 unmapped bank7", 4'h7, 2'd1, 32'd0);
        reg_rd("R2 unmapped bankF", 4'hF, 2'd0, 32'd0);
        reg_rd("R2 address untouched", 4'h0, 2'd1, 32'h2000_0040);

        // R6: increment per size
        for (int s = 0; s < 3; s++) begin
            reg_wr(4'h0, 2'd0, {26'd0, 2'b01, 1'b0, 3'(s)});
            reg_wr(4'h0, 2'd1, 32'h2000_0010);
            data_op(1'b1, 1'b0, 2'd0, 32'd0);
            reg_rd("R6 increment by size", 4'h0, 2'd1, 32'h2000_0010 + (32'd1 << s));
        end
        reg_wr(4'h0, 2'd0, 32'h0000_0022);
        data_op(1'b0, 1'b0, 2'd0, 32'h1234_5678);
        reg_rd("R6 mode 10 holds", 4'h0, 2'd1, m_tar);

        // R7: banked windows
        reg_wr(4'h0, 2'd0, 32'h0000_0010);
        reg_wr(4'h0, 2'd1, 32'h2000_0080);
        for (int n = 0; n < 4; n++) data_op(1'b0, 1'b1, 2'(n), 32'hA0A0_0000 + n);
        for (int n = 0; n < 4; n++) data_op(1'b1, 1'b1, 2'(n), 32'd0);
        reg_rd("R7 address unchanged", 4'h0, 2'd1, 32'h2000_0080);

        // R8: error with increment on
        reg_wr(4'h0, 2'd1, 32'hEE00_0100);
        data_op(1'b1, 1'b0, 2'd0, 32'd0);
        reg_rd("R8 no increment on error", 4'h0, 2'd1, 32'hEE00_0100);

        // R10: request during a stalled transfer is dropped
        begin
            int dones = 0;
            reg_wr(4'h0, 2'd1, 32'h2000_0004);
            reg_wr(4'h0, 2'd0, 32'h0000_0002);
            wcnt = 8;
            req_valid = 1'b1; req_rnw = 1'b1; req_bank = 4'h0; req_off = 2'd3;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_rnw = 1'b0; req_off = 2'd1; req_wdata = 32'h0000_1234;
            @(negedge clk);
            req_valid = 1'b0;
            for (int c = 0; c < 20; c++) begin
                if (resp_done) dones++;
                @(negedge clk);
            end
            chk("R10 single completion", dones, 1);
            chk("R11 stalled address", last_addr, 32'h2000_0004);
            reg_rd("R10 busy write dropped", 4'h0, 2'd1, 32'h2000_0004);
        end

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom % 10;
            case (op)
                0: reg_wr(4'h0, 2'd0, $urandom);
                1: reg_wr(4'h0, 2'd1, {(($urandom % 8) == 0) ? 8'hEE : 8'h20,
                                        16'd0, 8'($urandom)});
                2: reg_rd("R3 control word", 4'h0, 2'd0, {26'd0, m_inc, 1'b0, m_size});
                3: reg_rd("R6 address track", 4'h0, 2'd1, m_tar);
                4, 5: data_op(1'($urandom), 1'b0, 2'd0, $urandom);
                6, 7: data_op(1'($urandom), 1'b1, 2'($urandom), $urandom);
                8: reg_rd("R9 base", 4'hF, 2'd2, T_BASE);
                default: reg_rd("R2 unmapped", 4'($urandom % 13 + 2), 2'($urandom), 32'd0);
            endcase
        end
        reg_rd("R6 final address", 4'h0, 2'd1, m_tar);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule